// File: doc/BRIEF.md
# Receive Descriptor Walker

This block walks a receive descriptor list on behalf of an Ethernet DMA engine. A fetch unit reads each descriptor from memory and presents its control word and its two pointer words. The walker checks the buffer sizes and turns the descriptor into at most two buffer write commands for the frame that is arriving. Each command carries a word-aligned address, a byte shift and a byte length. The walker then computes where the next descriptor lives. That can be the list base (a ring that closes on itself), a pointer held in the descriptor (a chained list), or the next 16-byte slot.

Software loads the list base through a one-word register write and starts the walk with a strobe. The walker then asks for a descriptor at the address on `desc_addr`. For each descriptor the fetcher also supplies how many bytes of the frame remain, and whether this descriptor receives the first byte of the frame. The status word of the descriptor is not consumed here.

States: `S_IDLE` (waiting for start), `S_WAIT` (requesting a descriptor), `S_CHECK` (size validation), `S_BUF1` (first buffer), `S_BUF2` (second buffer), `S_DONE` (next-address pulse). Transitions:
- start: any state to `S_WAIT`.
- accept: `S_WAIT` to `S_CHECK` on `desc_valid`.
- reject: `S_CHECK` to `S_WAIT` on a bad size.
- go: `S_CHECK` to `S_BUF1`.
- second: `S_BUF1` to `S_BUF2` when bytes remain, the chained flag is clear and the second size is non-zero.
- finish: `S_BUF1` or `S_BUF2` to `S_DONE`.
- advance: `S_DONE` to `S_WAIT`.

Synchronous reset forces `S_IDLE`.

Top module: `rx_desc_walker`

## Requirements
- R1: After synchronous reset the walker is idle: `desc_req`, `cmd_valid`, `done` and `size_err` are all 0.
- R2: A `start` strobe loads the descriptor pointer from the base register, or from `cfg_base` when `cfg_we` is high in the same cycle. In the next cycle `desc_req` is 1 and `desc_addr` equals that base.
- R3: When control word bit 15 (ring end) is set, the next descriptor address is the base register. This holds even when bit 14 is also set.
- R4: When bit 14 (chained) is set and bit 15 is clear, the next descriptor address is `desc_w3`. No second-buffer command is issued, whatever the value of bits 28:16.
- R5: When bits 15 and 14 are both clear, the next descriptor address is the current descriptor address plus 16.
- R6: Bits 12:0 give the first buffer size in bytes. When that size is zero, no command is issued for the first buffer and the walk moves on to the second buffer.
- R7: Bits 28:16 give the second buffer size. The second buffer (address `desc_w3`) is written only when the chained flag is clear, its size is non-zero, and frame bytes remain after the first buffer.
- R8: Each command length is the smaller of the buffer size and the frame bytes still remaining. The remaining count drops by that length.
- R9: Every command address has bits 1:0 at zero. The first-buffer command that carries the start of a frame has `cmd_shift` equal to `desc_w2[1:0]`. Every other command has shift 0.
- R10: `done` is a one-cycle pulse. While it is high, `frame_cont` is 1 exactly when frame bytes remain.
- R11: A buffer size not a multiple of 4 raises `size_err` for one cycle (the second size is checked only when the chained flag is clear). It issues no command and no `done`, and the walker re-requests the same descriptor address.
- R12: Commands come in order: the first buffer (`cmd_buf`=0) before the second (`cmd_buf`=1). After `done`, `desc_addr` takes the pulsed next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the list base register |
| cfg_base | input | 32 | List base address |
| start | input | 1 | Begin walking at the list base |
| desc_req | output | 1 | Walker wants the descriptor at `desc_addr` |
| desc_addr | output | 32 | Current descriptor address |
| desc_valid | input | 1 | Descriptor words and frame info are valid |
| desc_w1 | input | 32 | Control word: flags and buffer sizes |
| desc_w2 | input | 32 | First buffer address |
| desc_w3 | input | 32 | Second buffer address or next-descriptor link |
| frame_rem | input | 16 | Frame bytes still to be placed |
| frame_sof | input | 1 | This descriptor receives the frame start |
| cmd_valid | output | 1 | Buffer write command valid |
| cmd_buf | output | 1 | 0 = first buffer, 1 = second buffer |
| cmd_addr | output | 32 | Word-aligned write address |
| cmd_shift | output | 2 | Byte shift of the data within the first word |
| cmd_len | output | 13 | Bytes to write |
| done | output | 1 | Descriptor finished, next address valid |
| next_desc_addr | output | 32 | Next descriptor address |
| frame_cont | output | 1 | Frame continues into the next descriptor |
| size_err | output | 1 | Buffer size not a multiple of 4 |

## Verification
On every cycle the assertions check several properties. They check the next-address choice against the latched flags, including the ring-over-chain precedence. They check that command addresses are word aligned and that a non-zero shift appears only on a first-buffer start-of-frame write. They also check the single-cycle `done`, that `size_err` never coincides with a command, and that the pointer advances after `done`. Only the bench scenarios can show the rest: the number of commands per descriptor, the zero-size skip, the split of a frame's bytes across both buffers and into a following descriptor, and the length values themselves. Each of these depends on the frame length that was applied.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_CHECK,
        S_BUF1,
        S_BUF2,
        S_DONE
    } walk_state_t;

    localparam int DESC_STRIDE = 16;
endpackage

// File: rtl/rxw_ctl_decode.sv
module rxw_ctl_decode #(
    parameter int WORD_W = 32,
    parameter int SZW    = 13
) (
    input  logic [WORD_W-1:0] ctl,
    output logic              ring_end,
    output logic              chained,
    output logic [SZW-1:0]    size1,
    output logic [SZW-1:0]    size2,
    output logic              size_bad
);
    localparam int SZ2_LO = 16;

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{ctl[WORD_W-1:SZ2_LO+SZW], ctl[SZW]};

    assign ring_end = ctl[15];
    assign chained  = ctl[14];
    assign size1    = ctl[SZW-1:0];
    assign size2    = ctl[SZ2_LO+SZW-1:SZ2_LO];
    assign size_bad = (size1[1:0] != 2'b00) || (!chained && (size2[1:0] != 2'b00));
endmodule

// File: rtl/rxw_buf_cmd.sv
module rxw_buf_cmd #(
    parameter int WORD_W = 32,
    parameter int SZW    = 13,
    parameter int LEN_W  = 16
) (
    input  logic [WORD_W-1:0] buf_ptr,
    input  logic [SZW-1:0]    size,
    input  logic [LEN_W-1:0]  rem,
    input  logic              keep_offset,
    output logic [WORD_W-1:0] addr,
    output logic [1:0]        shift,
    output logic [SZW-1:0]    len,
    output logic [LEN_W-1:0]  rem_left,
    output logic              has_data
);
    localparam int PAD = LEN_W - SZW;

    logic rem_smaller;
    assign rem_smaller = rem < {{PAD{1'b0}}, size};
    assign len         = rem_smaller ? rem[SZW-1:0] : size;
    assign rem_left    = rem - {{PAD{1'b0}}, len};
    assign has_data    = (size != '0) && (rem != '0);
    assign addr        = {buf_ptr[WORD_W-1:2], 2'b00};
    assign shift       = keep_offset ? buf_ptr[1:0] : 2'b00;
endmodule

// File: rtl/rxw_next_sel.sv
module rxw_next_sel #(
    parameter int WORD_W = 32,
    parameter int STRIDE = 16
) (
    input  logic              ring_end,
    input  logic              chained,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] link,
    output logic [WORD_W-1:0] nxt
);
    always_comb begin
        if (ring_end)
            nxt = base;
        else if (chained)
            nxt = link;
        else
            nxt = cur + WORD_W'(STRIDE);
    end
endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
    import rxw_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SZW    = 13,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_base,
    input  logic              start,
    output logic              desc_req,
    output logic [WORD_W-1:0] desc_addr,
    input  logic              desc_valid,
    input  logic [WORD_W-1:0] desc_w1,
    input  logic [WORD_W-1:0] desc_w2,
    input  logic [WORD_W-1:0] desc_w3,
    input  logic [LEN_W-1:0]  frame_rem,
    input  logic              frame_sof,
    output logic              cmd_valid,
    output logic              cmd_buf,
    output logic [WORD_W-1:0] cmd_addr,
    output logic [1:0]        cmd_shift,
    output logic [SZW-1:0]    cmd_len,
    output logic              done,
    output logic [WORD_W-1:0] next_desc_addr,
    output logic              frame_cont,
    output logic              size_err
);
    walk_state_t state_q, state_d;

    logic [WORD_W-1:0] base_q, ptr_q, w1_q, w2_q, w3_q;
    logic [LEN_W-1:0]  rem_q;
    logic              sof_q;

    logic              ring_end, chained, size_bad;
    logic [SZW-1:0]    size1, size2;
    logic [WORD_W-1:0] nxt;

    logic [WORD_W-1:0] addr1, addr2;
    logic [1:0]        shift1, shift2;
    logic [SZW-1:0]    len1, len2;
    logic [LEN_W-1:0]  left1, left2;
    logic              has1, has2;
    logic [LEN_W-1:0]  rem_after1;

    rxw_ctl_decode #(.WORD_W(WORD_W), .SZW(SZW)) u_decode (
        .ctl      (w1_q),
        .ring_end (ring_end),
        .chained  (chained),
        .size1    (size1),
        .size2    (size2),
        .size_bad (size_bad)
    );

    rxw_buf_cmd #(.WORD_W(WORD_W), .SZW(SZW), .LEN_W(LEN_W)) u_buf1 (
        .buf_ptr     (w2_q),
        .size        (size1),
        .rem         (rem_q),
        .keep_offset (sof_q),
        .addr        (addr1),
        .shift       (shift1),
        .len         (len1),
        .rem_left    (left1),
        .has_data    (has1)
    );

    rxw_buf_cmd #(.WORD_W(WORD_W), .SZW(SZW), .LEN_W(LEN_W)) u_buf2 (
        .buf_ptr     (w3_q),
        .size        (size2),
        .rem         (rem_q),
        .keep_offset (1'b0),
        .addr        (addr2),
        .shift       (shift2),
        .len         (len2),
        .rem_left    (left2),
        .has_data    (has2)
    );

    rxw_next_sel #(.WORD_W(WORD_W), .STRIDE(DESC_STRIDE)) u_next (
        .ring_end (ring_end),
        .chained  (chained),
        .base     (base_q),
        .cur      (ptr_q),
        .link     (w3_q),
        .nxt      (nxt)
    );

    assign rem_after1 = has1 ? left1 : rem_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = S_IDLE;
            S_WAIT:  if (desc_valid) state_d = S_CHECK;
            S_CHECK: state_d = size_bad ? S_WAIT : S_BUF1;
            S_BUF1:  state_d = (rem_after1 == '0 || chained || size2 == '0) ? S_DONE : S_BUF2;
            S_BUF2:  state_d = S_DONE;
            S_DONE:  state_d = S_WAIT;
            default: state_d = S_IDLE;
        endcase
        if (start)
            state_d = S_WAIT;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ptr_q  <= '0;
            w1_q   <= '0;
            w2_q   <= '0;
            w3_q   <= '0;
            rem_q  <= '0;
            sof_q  <= 1'b0;
        end else begin
            if (cfg_we)
                base_q <= cfg_base;
            if (start) begin
                ptr_q <= cfg_we ? cfg_base : base_q;
            end else begin
                unique case (state_q)
                    S_WAIT: if (desc_valid) begin
                        w1_q  <= desc_w1;
                        w2_q  <= desc_w2;
                        w3_q  <= desc_w3;
                        rem_q <= frame_rem;
                        sof_q <= frame_sof;
                    end
                    S_BUF1: if (has1) begin
                        rem_q <= left1;
                        sof_q <= 1'b0;
                    end
                    S_BUF2: if (has2) begin
                        rem_q <= left2;
                        sof_q <= 1'b0;
                    end
                    S_DONE:  ptr_q <= nxt;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        desc_req       = (state_q == S_WAIT);
        desc_addr      = ptr_q;
        cmd_valid      = 1'b0;
        cmd_buf        = 1'b0;
        cmd_addr       = addr1;
        cmd_shift      = shift1;
        cmd_len        = len1;
        done           = (state_q == S_DONE);
        next_desc_addr = nxt;
        frame_cont     = (rem_q != '0);
        size_err       = (state_q == S_CHECK) && size_bad;
        unique case (state_q)
            S_BUF1: cmd_valid = has1;
            S_BUF2: begin
                cmd_valid = has2 && !chained;
                cmd_buf   = 1'b1;
                cmd_addr  = addr2;
                cmd_shift = shift2;
                cmd_len   = len2;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rx_desc_walker_chk.sv
module rx_desc_walker_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [WORD_W-1:0] cfg_base,
    input logic              start,
    input logic              desc_req,
    input logic [WORD_W-1:0] desc_addr,
    input logic              cmd_valid,
    input logic              cmd_buf,
    input logic [WORD_W-1:0] cmd_addr,
    input logic [1:0]        cmd_shift,
    input logic              done,
    input logic [WORD_W-1:0] next_desc_addr,
    input logic              size_err,
    input logic [WORD_W-1:0] base_q,
    input logic [WORD_W-1:0] ptr_q,
    input logic [WORD_W-1:0] w1_q,
    input logic [WORD_W-1:0] w3_q,
    input logic              sof_q
);
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!desc_req && !cmd_valid && !done && !size_err));

    assert_start_loads_ptr_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (desc_req && desc_addr == $past(cfg_we ? cfg_base : base_q)));

    assert_ring_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (done && w1_q[15]) |-> (next_desc_addr == base_q));

    assert_chain_link_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !w1_q[15] && w1_q[14]) |-> (next_desc_addr == w3_q));

    assert_chain_no_buf2_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_buf) |-> !w1_q[14]);

    assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !w1_q[15] && !w1_q[14]) |-> (next_desc_addr == ptr_q + WORD_W'(16)));

    assert_cmd_aligned_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_addr[1:0] == 2'b00));

    assert_shift_only_sof_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_shift != 2'b00) |-> (sof_q && !cmd_buf));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        size_err |-> (!cmd_valid && !done));

    assert_err_retry_R11: assert property (@(posedge clk) disable iff (rst)
        (size_err && !start) |=> (desc_req && desc_addr == $past(desc_addr)));

    assert_done_advances_R12: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (desc_req && desc_addr == $past(next_desc_addr)));
endmodule

bind rx_desc_walker rx_desc_walker_chk #(.WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_we         (cfg_we),
    .cfg_base       (cfg_base),
    .start          (start),
    .desc_req       (desc_req),
    .desc_addr      (desc_addr),
    .cmd_valid      (cmd_valid),
    .cmd_buf        (cmd_buf),
    .cmd_addr       (cmd_addr),
    .cmd_shift      (cmd_shift),
    .done           (done),
    .next_desc_addr (next_desc_addr),
    .size_err       (size_err),
    .base_q         (base_q),
    .ptr_q          (ptr_q),
    .w1_q           (w1_q),
    .w3_q           (w3_q),
    .sof_q          (sof_q)
);

// File: tb/rx_desc_walker_test.sv
module rx_desc_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_base = '0;
    logic        start = 1'b0;
    logic        desc_req;
    logic [31:0] desc_addr;
    logic        desc_valid = 1'b0;
    logic [31:0] desc_w1 = '0, desc_w2 = '0, desc_w3 = '0;
    logic [15:0] frame_rem = '0;
    logic        frame_sof = 1'b0;
    logic        cmd_valid, cmd_buf;
    logic [31:0] cmd_addr;
    logic [1:0]  cmd_shift;
    logic [12:0] cmd_len;
    logic        done;
    logic [31:0] next_desc_addr;
    logic        frame_cont;
    logic        size_err;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] exp_base = '0;
    logic [31:0] exp_ptr = '0;

    always #4 clk = ~clk;

    rx_desc_walker uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base), .start(start),
        .desc_req(desc_req), .desc_addr(desc_addr), .desc_valid(desc_valid),
        .desc_w1(desc_w1), .desc_w2(desc_w2), .desc_w3(desc_w3),
        .frame_rem(frame_rem), .frame_sof(frame_sof),
        .cmd_valid(cmd_valid), .cmd_buf(cmd_buf), .cmd_addr(cmd_addr),
        .cmd_shift(cmd_shift), .cmd_len(cmd_len), .done(done),
        .next_desc_addr(next_desc_addr), .frame_cont(frame_cont), .size_err(size_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] min_len(input int sz, input int rem);
        return (rem < sz) ? rem : sz;
    endfunction

    task automatic do_start(input logic [31:0] base);
        @(negedge clk);
        cfg_we = 1'b1; cfg_base = base; start = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; start = 1'b0;
        exp_base = base;
        exp_ptr = base;
        chk("R2 desc_req after start", 32'(desc_req), 32'd1);
        chk("R2 desc_addr after start", desc_addr, base);
    endtask

    task automatic run_desc(input logic [31:0] w1, w2, w3, input int rem, input bit sof);
        int sz1 = int'(w1[12:0]);
        int sz2 = int'(w1[28:16]);
        bit eor = w1[15];
        bit ch = w1[14];
        bit bad = (sz1 % 4 != 0) || (!ch && (sz2 % 4 != 0));
        int e_n = 0;
        logic [31:0] e_addr[2], e_len[2], e_shift[2], e_buf[2];
        logic [31:0] g_addr[2], g_len[2], g_shift[2], g_buf[2];
        int r = rem;
        int g_n = 0;
        bit g_done = 0, g_err = 0, g_cont = 0;
        logic [31:0] g_next = '0;
        logic [31:0] e_next;
        bit s = sof;

        if (!bad) begin
            if (sz1 != 0 && r != 0) begin
                e_addr[e_n] = {w2[31:2], 2'b00};
                e_shift[e_n] = s ? 32'(w2[1:0]) : 32'd0;
                e_len[e_n] = min_len(sz1, r);
                e_buf[e_n] = 0;
                r -= int'(e_len[e_n]);
                s = 0;
                e_n++;
            end
            if (!ch && sz2 != 0 && r != 0) begin
                e_addr[e_n] = {w3[31:2], 2'b00};
                e_shift[e_n] = 0;
                e_len[e_n] = min_len(sz2, r);
                e_buf[e_n] = 1;
                r -= int'(e_len[e_n]);
                e_n++;
            end
        end
        e_next = eor ? exp_base : (ch ? w3 : exp_ptr + 32'd16);

        for (int k = 0; k < 20 && !desc_req; k++) @(negedge clk);
        chk("R2 desc_req before descriptor", 32'(desc_req), 32'd1);
        chk("R12 desc_addr tracks walk", desc_addr, exp_ptr);
        desc_valid = 1'b1; desc_w1 = w1; desc_w2 = w2; desc_w3 = w3;
        frame_rem = 16'(rem); frame_sof = sof;
        @(negedge clk);
        desc_valid = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (cmd_valid) begin
                if (g_n < 2) begin
                    g_addr[g_n] = cmd_addr; g_len[g_n] = 32'(cmd_len);
                    g_shift[g_n] = 32'(cmd_shift); g_buf[g_n] = 32'(cmd_buf);
                end
                g_n++;
            end
            if (size_err) g_err = 1;
            if (done) begin g_done = 1; g_next = next_desc_addr; g_cont = frame_cont; end
            if (done || size_err) break;
            @(negedge clk);
        end

        chk("R11 size_err raised", 32'(g_err), 32'(bad));
        chk("R6 R7 command count", 32'(g_n), 32'(e_n));
        for (int i = 0; i < 2; i++) begin
            if (i < e_n && i < g_n) begin
                chk("R9 command address", g_addr[i], e_addr[i]);
                chk("R8 command length", g_len[i], e_len[i]);
                chk("R9 command shift", g_shift[i], e_shift[i]);
                chk("R12 command buffer order", g_buf[i], e_buf[i]);
            end
        end
        chk("R11 done only when sizes valid", 32'(g_done), 32'(!bad));
        if (!bad && g_done) begin
            if (eor) chk("R3 next is base", g_next, e_next);
            else if (ch) chk("R4 next is link", g_next, e_next);
            else chk("R5 next is plus 16", g_next, e_next);
            chk("R10 frame_cont", 32'(g_cont), 32'(r != 0));
            @(negedge clk);
            chk("R10 done is one cycle", 32'(done), 32'd0);
            exp_ptr = e_next;
        end
    endtask

    function automatic logic [31:0] mk_ctl(input bit eor, input bit ch, input int sz1, input int sz2);
        return {3'b000, 13'(sz2), eor, ch, 1'b0, 13'(sz1)};
    endfunction

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                miscompares++;
                $display("FAIL watchdog expired");
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 desc_req after reset", 32'(desc_req), 32'd0);
        chk("R1 cmd_valid after reset", 32'(cmd_valid), 32'd0);
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 size_err after reset", 32'(size_err), 32'd0);

        do_start(32'h0000_1000);
        // R3: both flags set, ring end wins
        run_desc(mk_ctl(1, 1, 32, 64), 32'h0000_2000, 32'h0000_5550, 16, 1);
        // R4: chained, buffer 2 size ignored
        run_desc(mk_ctl(0, 1, 8, 64), 32'h0000_3000, 32'h0000_4440, 40, 0);
        // R5: plain step, split across both buffers (R7 R8)
        run_desc(mk_ctl(0, 0, 8, 64), 32'h0000_6000, 32'h0000_7004, 20, 0);
        // R6: zero first size skipped
        run_desc(mk_ctl(0, 0, 0, 32), 32'h0000_6100, 32'h0000_7100, 12, 1);
        // R9: start of frame with offset 3
        run_desc(mk_ctl(0, 0, 16, 0), 32'h0000_2003, 32'h0, 10, 1);
        // R9: not start of frame, offset dropped
        run_desc(mk_ctl(0, 0, 16, 0), 32'h0000_2003, 32'h0, 10, 0);
        // R10: frame continues past both buffers
        run_desc(mk_ctl(0, 0, 8, 8), 32'h0000_8000, 32'h0000_9000, 100, 1);
        // R11: misaligned first size
        run_desc(mk_ctl(0, 0, 6, 8), 32'h0000_8000, 32'h0000_9000, 20, 0);
        // R11: misaligned second size ignored when chained
        run_desc(mk_ctl(0, 1, 8, 6), 32'h0000_8000, 32'h0000_a000, 20, 0);

        for (int n = 0; n < 120; n++) begin
            bit eor = ($urandom_range(0, 7) == 0);
            bit ch = $urandom_range(0, 1) != 0;
            int sz1 = ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(1, 16)) * 4;
            int sz2 = int'($urandom_range(0, 16)) * 4;
            if ($urandom_range(0, 9) == 0) sz1 += 2;
            if ($urandom_range(0, 9) == 0) sz2 += 1;
            if (n % 30 == 29) do_start({$urandom_range(0, 65535), 4'h0});
            run_desc(mk_ctl(eor, ch, sz1, sz2), $urandom(),
                     {$urandom_range(0, 65535), 4'h0},
                     int'($urandom_range(1, 150)), $urandom_range(0, 1) != 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule